// File: doc/BRIEF.md
# Staged Reset Sequencer

This block generates the system reset for a small processor subsystem. It runs from the slow RC clock. When the supply-good input is high, it waits a fixed number of slow-clock cycles for the RC oscillator to settle. It then enables the crystal oscillator and the logic supply, and holds the processor and peripheral resets for a second fixed window while the crystal settles. Only after both windows does it release reset, and the processor then fetches from its fixed reset vector.

Four run-time causes restart the sequence from the RC-settle window:
- an external active-low reset pin,
- a software request,
- a watchdog expiry,
- a brown-out flag.

Each of these passes through a two-flop synchroniser first. Loss of supply is handled differently: it clears the whole block at once, without waiting for a clock edge. A 3-bit cause register records the highest-priority cause seen most recently. It stays valid after release. A pin indication shows whether the supply is up, independently of the internal reset.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `pwr_good_i` is low, without any clock edge, `rst_pin_o`, `xtal_en_o` and `sys_rst_n_o` are 0 and `cause_o` is 1 (power-on).
- R2: After `pwr_good_i` rises, the sequence enters the RC window on the third rising clock edge (two synchroniser stages). `xtal_en_o` stays 0 for exactly RC_CYCLES edges of that window.
- R3: `xtal_en_o` goes to 1 when the RC window ends. `sys_rst_n_o` stays 0 for the following XTAL_CYCLES edges.
- R4: `sys_rst_n_o` goes to 1 only after the crystal window, and `xtal_en_o` stays 1 while reset is released.
- R5: `rst_pin_o` is 1 whenever the supply is good, including both settle windows.
- R6: A software request, watchdog expiry, brown-out or low external pin that is held across a rising edge drives `sys_rst_n_o` and `xtal_en_o` to 0 on the third rising edge. The sequence then restarts from the RC window.
- R7: `cause_o` codes are 1 power-on, 2 brown-out, 3 external pin, 4 watchdog and 5 software. When several causes are active together, the lowest code among them is recorded.
- R8: `cause_o` keeps its value after release until another cause fires.
- R9: A cause that stays active holds the block at the start of the RC window. The full two-window sequence then runs again after the cause goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow_i | input | 1 | Slow RC oscillator clock |
| pwr_good_i | input | 1 | Supply above threshold; low clears the block asynchronously |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| sw_req_i | input | 1 | Software reset request, asynchronous |
| wdt_exp_i | input | 1 | Watchdog expiry, asynchronous |
| bod_i | input | 1 | Brown-out detected, asynchronous |
| xtal_en_o | output | 1 | Crystal oscillator and logic supply enable |
| sys_rst_n_o | output | 1 | Processor and peripheral reset, active low |
| rst_pin_o | output | 1 | Reset pin indication: supply is up |
| cause_o | output | 3 | Last recorded reset cause |

## Verification
The assertions assume the following about the inputs:
- Reset causes are levels that stay stable across a clock edge, so that the synchronised copies match what was driven two edges earlier.
- `pwr_good_i` is the only input that is allowed to act without a clock.

The stimulus meets this by changing every input on the falling clock edge and holding each cause for at least one full cycle. Supply loss is also applied on a falling edge, so the asynchronous clear never coincides with a rising edge.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RC   = 2'd1,
        ST_XTAL = 2'd2,
        ST_RUN  = 2'd3
    } seq_state_e;

    // cause codes (R7)
    localparam logic [2:0] CAUSE_POR = 3'd1;
    localparam logic [2:0] CAUSE_BOD = 3'd2;
    localparam logic [2:0] CAUSE_EXT = 3'd3;
    localparam logic [2:0] CAUSE_WDT = 3'd4;
    localparam logic [2:0] CAUSE_SW  = 3'd5;

    // source vector index order equals priority: 0 brown-out .. 3 software
    localparam int SRC_N = 4;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             clr_n_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;
        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din_i[g]};
        end
        always_ff @(posedge clk_i or negedge clr_n_i) begin
            if (!clr_n_i) chain_q <= '0;
            else          chain_q <= chain_d;
        end
        assign dout_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/rstseq_prio.sv
module rstseq_prio
    import rstseq_pkg::*;
(
    input  logic [SRC_N-1:0] act_i,
    output logic             any_o,
    output logic [2:0]       code_o
);
    always_comb begin
        any_o  = |act_i;
        code_o = CAUSE_POR;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (act_i[i]) code_o = CAUSE_BOD + 3'(i);
        end
    end
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int RC_CYCLES   = 4,
    parameter int XTAL_CYCLES = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_slow_i,
    input  logic       pwr_good_i,
    input  logic       ext_rst_n_i,
    input  logic       sw_req_i,
    input  logic       wdt_exp_i,
    input  logic       bod_i,
    output logic       xtal_en_o,
    output logic       sys_rst_n_o,
    output logic       rst_pin_o,
    output logic [2:0] cause_o
);
    localparam int MAX_CYC = (RC_CYCLES > XTAL_CYCLES) ? RC_CYCLES : XTAL_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RC_LAST   = CNT_W'(RC_CYCLES - 1);
    localparam logic [CNT_W-1:0] XTAL_LAST = CNT_W'(XTAL_CYCLES - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       cause;
    } seq_regs_t;

    seq_regs_t regs_d, regs_q;

    logic             pwr_ok;
    logic [SRC_N-1:0] src_raw, src_sync;
    logic             src_any;
    logic [2:0]       src_code;

    rstseq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_pwr_sync (
        .clk_i   (clk_slow_i),
        .clr_n_i (pwr_good_i),
        .din_i   (1'b1),
        .dout_o  (pwr_ok)
    );

    assign src_raw = {sw_req_i, wdt_exp_i, ~ext_rst_n_i, bod_i};

    rstseq_sync #(.WIDTH(SRC_N), .STAGES(SYNC_STAGES)) i_src_sync (
        .clk_i   (clk_slow_i),
        .clr_n_i (pwr_good_i),
        .din_i   (src_raw),
        .dout_o  (src_sync)
    );

    rstseq_prio i_prio (
        .act_i  (src_sync),
        .any_o  (src_any),
        .code_o (src_code)
    );

    always_comb begin
        regs_d = regs_q;
        if (regs_q.state == ST_OFF) begin
            if (pwr_ok) begin
                regs_d.state = ST_RC;
                regs_d.cnt   = '0;
                regs_d.cause = CAUSE_POR;
            end
        end else if (src_any) begin
            regs_d.state = ST_RC;
            regs_d.cnt   = '0;
            regs_d.cause = src_code;
        end else begin
            unique case (regs_q.state)
                ST_RC: begin
                    if (regs_q.cnt == RC_LAST) begin
                        regs_d.state = ST_XTAL;
                        regs_d.cnt   = '0;
                    end else begin
                        regs_d.cnt = regs_q.cnt + 1'b1;
                    end
                end
                ST_XTAL: begin
                    if (regs_q.cnt == XTAL_LAST) begin
                        regs_d.state = ST_RUN;
                        regs_d.cnt   = '0;
                    end else begin
                        regs_d.cnt = regs_q.cnt + 1'b1;
                    end
                end
                default: regs_d.cnt = '0;
            endcase
        end
    end

    always_ff @(posedge clk_slow_i or negedge pwr_good_i) begin
        if (!pwr_good_i) begin
            regs_q.state <= ST_OFF;
            regs_q.cnt   <= '0;
            regs_q.cause <= CAUSE_POR;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign xtal_en_o   = (regs_q.state == ST_XTAL) || (regs_q.state == ST_RUN);
    assign sys_rst_n_o = (regs_q.state == ST_RUN);
    assign rst_pin_o   = (regs_q.state != ST_OFF);
    assign cause_o     = regs_q.cause;

    // R4
    release_after_xtal_chk: assert property (@(posedge clk_slow_i) disable iff (!pwr_good_i)
        $rose(sys_rst_n_o) |-> $past(xtal_en_o) && !$past(src_any));

    // R6
    source_forces_reset_chk: assert property (@(posedge clk_slow_i) disable iff (!pwr_good_i)
        (src_any && rst_pin_o) |=> (!sys_rst_n_o && !xtal_en_o && cause_o == $past(src_code)));

    // R8
    cause_held_chk: assert property (@(posedge clk_slow_i) disable iff (!pwr_good_i)
        (sys_rst_n_o && !src_any) |=> $stable(cause_o));

    // R2
    xtal_gated_by_rc_chk: assert property (@(posedge clk_slow_i) disable iff (!pwr_good_i)
        $rose(xtal_en_o) |-> $past(rst_pin_o) && !$past(sys_rst_n_o));

    // R5
    pin_before_release_chk: assert property (@(posedge clk_slow_i) disable iff (!pwr_good_i)
        sys_rst_n_o |-> rst_pin_o);
endmodule

// File: tb/test_rstseq_ctrl.sv
module test_rstseq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int RC_N   = 4;
    localparam int XTAL_N = 25;
    localparam int SEQ_N  = RC_N + XTAL_N;

    logic clk = 1'b0;
    logic pwr_good = 1'b0, ext_rst_n = 1'b1, sw_req = 1'b0, wdt_exp = 1'b0, bod = 1'b0;
    logic xtal_en, sys_rst_n, rst_pin;
    logic [2:0] cause;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstseq_ctrl i_rstseq_ctrl (
        .clk_slow_i(clk), .pwr_good_i(pwr_good), .ext_rst_n_i(ext_rst_n),
        .sw_req_i(sw_req), .wdt_exp_i(wdt_exp), .bod_i(bod),
        .xtal_en_o(xtal_en), .sys_rst_n_o(sys_rst_n), .rst_pin_o(rst_pin), .cause_o(cause)
    );

    // behavioural reference: phase 0 off, 1 rc, 2 xtal, 3 run
    int m_phase = 0, m_left = 0, m_cause = 1;
    bit pw1 = 0, pw2 = 0;
    bit [3:0] s1 = 0, s2 = 0; // {sw,wdt,ext,bod}

    always @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            m_phase <= 0; m_left <= 0; m_cause <= 1;
            pw1 <= 0; pw2 <= 0; s1 <= 0; s2 <= 0;
        end else begin
            pw1 <= 1; pw2 <= pw1;
            s1 <= {sw_req, wdt_exp, !ext_rst_n, bod}; s2 <= s1;
            if (m_phase == 0) begin
                if (pw2) begin m_phase <= 1; m_left <= RC_N - 1; m_cause <= 1; end
            end else if (s2 != 0) begin
                m_phase <= 1; m_left <= RC_N - 1;
                m_cause <= s2[0] ? 2 : s2[1] ? 3 : s2[2] ? 4 : 5;
            end else if (m_phase == 1) begin
                if (m_left == 0) begin m_phase <= 2; m_left <= XTAL_N - 1; end
                else m_left <= m_left - 1;
            end else if (m_phase == 2) begin
                if (m_left == 0) m_phase <= 3;
                else m_left <= m_left - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison with the reference
    always @(posedge clk) begin
        #1;
        if (!done) begin
            chk(rst_pin == (m_phase != 0), "R5 model pin", int'(rst_pin), int'(m_phase != 0));
            chk(xtal_en == (m_phase >= 2), "R3 model xtal", int'(xtal_en), int'(m_phase >= 2));
            chk(sys_rst_n == (m_phase == 3), "R4 model release", int'(sys_rst_n), int'(m_phase == 3));
            chk(int'(cause) == m_cause, "R7 model cause", int'(cause), m_cause);
        end
    end

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // drive a cause at a negedge, hold it for hold_n cycles, check the restart
    task automatic fire(input int which, input int hold_n, input int exp_cause, input string tag);
        if (which[0]) bod = 1;
        if (which[1]) ext_rst_n = 0;
        if (which[2]) wdt_exp = 1;
        if (which[3]) sw_req = 1;
        edges(3);
        chk(!sys_rst_n && !xtal_en, {tag, " R6 reset taken"}, int'(sys_rst_n), 0);
        chk(int'(cause) == exp_cause, {tag, " R7 cause"}, int'(cause), exp_cause);
        if (hold_n > 3) begin
            edges(hold_n - 3);
            chk(!xtal_en && !sys_rst_n, {tag, " R9 held in rc"}, int'(xtal_en), 0);
        end
        bod = 0; ext_rst_n = 1; wdt_exp = 0; sw_req = 0;
        edges(2 + SEQ_N - 1);
        chk(!sys_rst_n, {tag, " R9 still in reset"}, int'(sys_rst_n), 0);
        edges(1);
        chk(sys_rst_n, {tag, " R9 released"}, int'(sys_rst_n), 1);
        edges(5);
        chk(int'(cause) == exp_cause, {tag, " R8 cause held"}, int'(cause), exp_cause);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk(0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        edges(3);
        chk(!rst_pin && !xtal_en && !sys_rst_n, "R1 off state", int'(rst_pin), 0);
        chk(cause == 3'd1, "R1 cause por", int'(cause), 1);
        pwr_good = 1;
        edges(2);
        chk(!rst_pin, "R2 sync delay", int'(rst_pin), 0);
        edges(1);
        chk(rst_pin && !xtal_en, "R5 pin up in rc", int'(rst_pin), 1);
        edges(RC_N - 1);
        chk(!xtal_en, "R2 rc window end", int'(xtal_en), 0);
        edges(1);
        chk(xtal_en && !sys_rst_n, "R3 xtal on, reset held", int'(xtal_en), 1);
        edges(XTAL_N - 1);
        chk(!sys_rst_n, "R3 last xtal cycle", int'(sys_rst_n), 0);
        edges(1);
        chk(sys_rst_n && xtal_en, "R4 release", int'(sys_rst_n), 1);
        chk(cause == 3'd1, "R8 por held", int'(cause), 1);

        fire(4'b1000, 1, 5, "sw");
        fire(4'b0100, 1, 4, "wdt");
        fire(4'b0010, 1, 3, "ext");
        fire(4'b0001, 1, 2, "bod");
        fire(4'b1110, 1, 3, "ext+wdt+sw R7");
        fire(4'b0011, 1, 2, "bod+ext R7");
        fire(4'b0100, 20, 4, "wdt held R9");

        edges(3);
        pwr_good = 0;
        #1;
        chk(!rst_pin && !xtal_en && !sys_rst_n, "R1 async drop", int'(rst_pin), 0);
        chk(cause == 3'd1, "R1 cause after drop", int'(cause), 1);
        edges(4);
        pwr_good = 1;
        edges(3 + SEQ_N - 1);
        chk(!sys_rst_n, "R2 restart pending", int'(sys_rst_n), 0);
        edges(1);
        chk(sys_rst_n, "R4 release after restart", int'(sys_rst_n), 1);
        edges(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule